// File: doc/BRIEF.md
# UART Receive FIFO with Character Timeout

This block sits behind the shift register of a serial receiver. Each completed character comes in with three error flags: parity error, framing error and break. The block keeps the character and its flags together as one tagged entry in a first-in first-out store. The oldest entry is shown to the host through a read-only holding register. The flags of that head entry appear in the line status bits, and a host read advances the store to the next entry.

A receive-data request is raised when the fill level reaches a selectable trigger level. A level of one gives a request per character. Data can sit below the trigger level. For that case a character timer runs on the 16x baud tick, and it forces the request once the line has been quiet for four word lengths plus twelve bit times. When the store is switched off, it acts as a one-entry holding register.

Top module: `uart_rx_fifo_tmo`

## Requirements
- R1: The holding register `rhr_o` shows the data of the oldest stored entry. The store takes up to 16 entries. A read strobe on `rhr_rd_i` removes the head, and the next entry is visible in the cycle after the read. A read while the store is empty has no effect. When the store is empty, `rhr_o` is 0.
- R2: `lsr_o[2]` carries the parity flag, `lsr_o[3]` the framing flag and `lsr_o[4]` the break flag of the current head entry. The flags travel with their own character, and they are 0 when the store is empty.
- R3: `lsr_o[0]` is 1 exactly when at least one entry is stored.
- R4: A character that arrives while the store is at capacity is dropped, and it sets the sticky overrun bit `lsr_o[1]`. A strobe on `lsr_rd_i` clears that bit. A write and a read in the same cycle at capacity are both accepted.
- R5: With `fifo_en_i` = 0, the capacity is one entry. Any change of `fifo_en_i` empties the store in that cycle, and a write in that cycle is discarded without setting overrun.
- R6: `rx_pend_o` is 1 when the fill level is at least the trigger level, or when the timeout flag is set. The trigger level is selected by `trig_sel_i`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With `fifo_en_i` = 0 the trigger level is always 1.
- R7: `irq_o` equals `rx_pend_o` gated by `rx_irq_en_i`.
- R8: The timeout limit in 16x ticks is 16*(4*(d+2)+12), where d = 5, 6, 7 or 8 data bits for `word_len_i` = 00, 01, 10 or 11 (640 to 832 ticks). The timer counts `tick16_i` pulses only while the store is not empty. When the count reaches the limit, `tmo_o` is set.
- R9: The timer restarts on every accepted write or read. A write in the cycle the limit would be reached prevents the timeout. An accepted read clears `tmo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle pulse at 16x the baud rate |
| fifo_en_i | input | 1 | 1: 16-entry store, 0: single holding entry |
| trig_sel_i | input | 2 | Trigger level select |
| word_len_i | input | 2 | Data bits per character: 00=5, 01=6, 10=7, 11=8 |
| rx_irq_en_i | input | 1 | Receive-data interrupt enable |
| char_valid_i | input | 1 | A completed character is presented |
| char_data_i | input | 8 | Character data |
| char_par_err_i | input | 1 | Parity error flag of the character |
| char_frm_err_i | input | 1 | Framing error flag of the character |
| char_brk_i | input | 1 | Break flag of the character |
| rhr_rd_i | input | 1 | Host reads the holding register |
| lsr_rd_i | input | 1 | Host reads line status, clears overrun |
| rhr_o | output | 8 | Holding register data |
| lsr_o | output | 5 | Line status: [0] ready, [1] overrun, [4:2] head flags |
| rx_pend_o | output | 1 | Receive-data request pending |
| tmo_o | output | 1 | Character timeout flag |
| irq_o | output | 1 | Receive-data interrupt |

## Verification
Two pairs of events can fall in the same cycle. A host read and an incoming character can coincide, including when the store is at capacity, so the pop and the push must both take effect without a false overrun. An incoming character can also coincide with the tick that would complete the timeout window, and then the restart has to win. The bench provokes the first pair directly at capacity and through random read/write traffic. It provokes the second by writing exactly on the expiry tick after counting the full 832-tick window. A bench model tracks the store contents, the overrun bit and the timer, and every cycle is judged against it.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned DATA_W         = 8;
  localparam int unsigned OVS            = 16;  // ticks per bit
  localparam int unsigned TMO_WORDS      = 4;
  localparam int unsigned TMO_EXTRA_BITS = 12;
  localparam int unsigned FRAME_OVERHEAD = 2;   // start + one stop
  localparam int unsigned MIN_DATA_BITS  = 5;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int unsigned ENTRY_W = $bits(rx_entry_t);

  function automatic int unsigned tmo_ticks(input logic [1:0] wl);
    return OVS * (TMO_WORDS * (MIN_DATA_BITS + 32'(wl) + FRAME_OVERHEAD) + TMO_EXTRA_BITS);
  endfunction

  function automatic int unsigned trig_level(input logic [1:0] sel, input logic fifo_on);
    if (!fifo_on) return 1;
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  localparam int unsigned MAX_TMO = tmo_ticks(2'b11);
endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 11,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          cap_one_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, cap;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap       = cap_one_i ? CW'(1) : CW'(DEPTH);
  assign pop_ok_o  = pop_i & ~flush_i & (count_q != '0);
  assign push_ok_o = push_i & ~flush_i & ((count_q < cap) | pop_ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok_o)  rd_ptr_q <= nxt(rd_ptr_q);
      count_q <= count_q + CW'(push_ok_o) - CW'(pop_ok_o);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r4_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CW'(DEPTH) && push_i && !pop_i && !flush_i) |=> count_q == CW'(DEPTH));
  a_r5_single_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_one_i && !flush_i) |-> count_q <= CW'(1));
endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer #(
  parameter int unsigned TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic          idle_i,
  input  logic          clear_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;
  logic          hit, exp_q;

  assign hit = tick_i & ~restart_i & ~idle_i & (cnt_q == limit_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i | idle_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= hit ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      exp_q <= 1'b0;
    else if (clear_i) exp_q <= 1'b0;
    else if (hit)     exp_q <= 1'b1;
  end

  assign expired_o = exp_q;

  a_r9_restart_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !expired_o) |=> !expired_o);
  a_r8_idle_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !expired_o) |=> !expired_o);
endmodule

// File: rtl/uart_rx_fifo_tmo.sv
module uart_rx_fifo_tmo
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              fifo_en_i,
  input  logic [1:0]        trig_sel_i,
  input  logic [1:0]        word_len_i,
  input  logic              rx_irq_en_i,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_par_err_i,
  input  logic              char_frm_err_i,
  input  logic              char_brk_i,
  input  logic              rhr_rd_i,
  input  logic              lsr_rd_i,
  output logic [DATA_W-1:0] rhr_o,
  output logic [4:0]        lsr_o,
  output logic              rx_pend_o,
  output logic              tmo_o,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned TW = $clog2(MAX_TMO + 1);

  logic          fen_q, flush, push_ok, pop_ok, nonempty, ovr_q, tmo;
  logic [CW-1:0] count;
  rx_entry_t     din, head;
  logic [TW-1:0] limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fen_q <= 1'b0;
    else         fen_q <= fifo_en_i;
  end
  assign flush = fifo_en_i ^ fen_q;

  assign din = '{brk: char_brk_i, frm: char_frm_err_i, par: char_par_err_i, data: char_data_i};

  rx_tag_fifo #(.DEPTH(DEPTH), .W(ENTRY_W), .CW(CW)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .cap_one_i (~fifo_en_i),
    .push_i    (char_valid_i),
    .pop_i     (rhr_rd_i),
    .din_i     (din),
    .dout_o    (head),
    .count_o   (count),
    .push_ok_o (push_ok),
    .pop_ok_o  (pop_ok)
  );

  assign nonempty = (count != '0);

  // sticky overrun; a new drop wins over a clearing status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= (ovr_q & ~lsr_rd_i) | (char_valid_i & ~push_ok & ~flush);
  end

  assign limit = TW'(tmo_ticks(word_len_i));

  rx_char_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .restart_i (push_ok | pop_ok | flush),
    .idle_i    (~nonempty),
    .clear_i   (pop_ok | flush),
    .limit_i   (limit),
    .expired_o (tmo)
  );

  assign rhr_o     = nonempty ? head.data : '0;
  assign lsr_o     = {nonempty ? {head.brk, head.frm, head.par} : 3'b000, ovr_q, nonempty};
  assign rx_pend_o = (32'(count) >= trig_level(trig_sel_i, fifo_en_i)) | tmo;
  assign tmo_o     = tmo;
  assign irq_o     = rx_irq_en_i & rx_pend_o;

  a_r7_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_irq_en_i);
  a_r9_tmo_only_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> lsr_o[0]);
  a_r9_read_clears_tmo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok |=> !tmo_o);
  a_r4_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_o[1] && !lsr_rd_i) |=> lsr_o[1]);
endmodule

// File: tb/uart_rx_fifo_tmo_tb_top.sv
module uart_rx_fifo_tmo_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       tick = 0, fen = 1, en = 1, valid = 0, pe = 0, fe = 0, bk = 0, rd = 0, lrd = 0;
  logic [1:0] sel = 2'b11, wl = 2'b00;
  logic [7:0] dat = 0;
  logic [7:0] rhr;
  logic [4:0] lsr;
  logic       pend, tmo, irq;

  uart_rx_fifo_tmo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .fifo_en_i(fen), .trig_sel_i(sel),
    .word_len_i(wl), .rx_irq_en_i(en), .char_valid_i(valid), .char_data_i(dat),
    .char_par_err_i(pe), .char_frm_err_i(fe), .char_brk_i(bk), .rhr_rd_i(rd),
    .lsr_rd_i(lrd), .rhr_o(rhr), .lsr_o(lsr), .rx_pend_o(pend), .tmo_o(tmo), .irq_o(irq)
  );

  int tests = 0, fails = 0;
  logic [10:0] mq[$];
  logic m_ovr = 0, m_tmo = 0, m_fprev = 0;
  int   m_cnt = 0;

  function automatic int f_trig(logic [1:0] s, logic f);
    if (!f) return 1;
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 14;
  endfunction
  function automatic int f_lim(logic [1:0] w);
    return 16 * (4 * (5 + int'(w) + 2) + 12);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit flush, rok, wok, empty_pre, hit;
    int cap;
    flush = (fen != m_fprev);
    m_fprev = fen;
    cap = fen ? 16 : 1;
    empty_pre = (mq.size() == 0);
    rok = !flush && rd && mq.size() > 0;
    wok = !flush && valid && (mq.size() < cap || rok);
    m_ovr = (m_ovr && !lrd) || (valid && !wok && !flush);
    hit = 0;
    if (wok || rok || flush || empty_pre) m_cnt = 0;
    else if (tick) begin
      if (m_cnt == f_lim(wl) - 1) begin hit = 1; m_cnt = 0; end
      else m_cnt++;
    end
    if (rok || flush) m_tmo = 0;
    else if (hit) m_tmo = 1;
    if (flush) mq.delete();
    if (rok) void'(mq.pop_front());
    if (wok) mq.push_back({bk, fe, pe, dat});
  endtask

  task automatic compare_all();
    logic [10:0] h;
    logic exp_pend;
    h = (mq.size() > 0) ? mq[0] : 11'd0;
    exp_pend = (mq.size() >= f_trig(sel, fen)) || m_tmo;
    chk("R1 rhr", 32'(rhr), 32'(h[7:0]));
    chk("R2 tags", 32'(lsr[4:2]), 32'(h[10:8]));
    chk("R3 ready", 32'(lsr[0]), 32'(mq.size() > 0));
    chk("R4 overrun", 32'(lsr[1]), 32'(m_ovr));
    chk("R6 pend", 32'(pend), 32'(exp_pend));
    chk("R7 irq", 32'(irq), 32'(en && exp_pend));
    chk("R8 tmo", 32'(tmo), 32'(m_tmo));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    valid = 0; rd = 0; lrd = 0;
  endtask

  task automatic put(logic [7:0] d, logic [2:0] t);
    valid = 1; dat = d; {bk, fe, pe} = t;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R3 reset ready", 32'(lsr), 32'd0);
    chk("R7 reset irq", 32'(irq), 32'd0);
    rst_n = 1;
    step();

    // R1/R6: fill to capacity with trigger 14
    for (int i = 0; i < 16; i++) begin
      put(8'(8'h30 + i), 3'(i));
      if (i == 12) chk("R6 below trigger", 32'(pend), 32'd0);
      if (i == 13) chk("R6 at trigger", 32'(pend), 32'd1);
    end
    put(8'hEE, 3'b111);
    chk("R4 drop sets overrun", 32'(lsr[1]), 32'd1);
    chk("R4 head unchanged", 32'(rhr), 32'h30);
    valid = 1; rd = 1; dat = 8'hA5; {bk, fe, pe} = 3'b101;
    step();
    chk("R4 simultaneous read+write at full", 32'(rhr), 32'h31);
    chk("R2 next tags", 32'(lsr[4:2]), 32'd1);
    chk("R4 no false overrun clear", 32'(lsr[1]), 32'd1);
    lrd = 1; step();
    chk("R4 status read clears", 32'(lsr[1]), 32'd0);
    while (mq.size() > 0) begin rd = 1; step(); end
    rd = 1; step();
    chk("R1 read while empty", 32'(rhr), 32'd0);

    // R5: single holding entry
    fen = 0; step();
    put(8'h11, 3'b010);
    put(8'h22, 3'b000);
    chk("R5 single entry keeps first", 32'(rhr), 32'h11);
    chk("R5 second sets overrun", 32'(lsr[1]), 32'd1);
    chk("R5 trigger forced to 1", 32'(pend), 32'd1);
    fen = 1; step();
    chk("R5 mode change empties", 32'(lsr[0]), 32'd0);
    lrd = 1; step();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      if (n % 250 == 0) begin
        sel = 2'($urandom);
        fen = ($urandom % 10) != 0;
        wl  = 2'($urandom);
      end
      valid = ($urandom % 100) < 55;
      rd    = ($urandom % 100) < 45;
      lrd   = ($urandom % 100) < 5;
      tick  = ($urandom % 2) == 1;
      dat   = 8'($urandom);
      {bk, fe, pe} = 3'($urandom);
      step();
    end

    // timeout tests
    tick = 0; fen = 1; sel = 2'b11; en = 1; wl = 2'b00;
    step();
    while (mq.size() > 0) begin rd = 1; step(); end
    lrd = 1; step();
    tick = 1;
    put(8'h5A, 3'b000);
    repeat (639) step();
    chk("R8 no timeout at limit-1", 32'(tmo), 32'd0);
    step();
    chk("R8 timeout at 640 ticks", 32'(tmo), 32'd1);
    chk("R7 irq from timeout", 32'(irq), 32'd1);
    en = 0; step();
    chk("R7 irq gated", 32'(irq), 32'd0);
    en = 1;
    rd = 1; step();
    chk("R9 read clears timeout", 32'(tmo), 32'd0);

    wl = 2'b11;
    put(8'h6B, 3'b100);
    repeat (831) step();
    put(8'h6C, 3'b000);
    chk("R9 write on expiry tick restarts", 32'(tmo), 32'd0);
    repeat (831) step();
    chk("R9 restarted window not yet expired", 32'(tmo), 32'd0);
    step();
    chk("R8 timeout at 832 ticks", 32'(tmo), 32'd1);
    tick = 0;
    repeat (20) step();
    chk("R8 flag holds without ticks", 32'(tmo), 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule